// File: doc/BRIEF.md
# UART Receiver with Address Filter

This block receives asynchronous serial characters on one input line. A 16x oversampling tick drives it. It checks the start bit at mid-bit, then shifts in either 8 data bits plus a stop bit, or 9 data bits plus a stop bit. The bits arrive least significant first. When a character completes, the block decides whether to present it to software. It raises the receive flag only if the flag is free and the multiprocessor rules pass. In 9-bit mode with the multiprocessor enable set, an address character (ninth bit 1) must also match either the masked own address or the broadcast address.

A line held low for 11 bit times is reported as a break. After that the receiver waits until the line goes high again before it looks for a new start bit. Software clears the receive flag with a one-cycle strobe. A second strobe clears both the framing error and the break flag. Generating the baud tick, transmitting, and any reset triggered by a break are handled outside this block.

The frame state machine has five states:

| State | Meaning |
|---|---|
| RX_IDLE | Waits for a low sample. |
| RX_START | Counts to mid-bit. A high sample there takes the "false start" transition back to RX_IDLE; a low sample takes the "start confirmed" transition to RX_DATA. |
| RX_DATA | Samples each bit at its sixteenth tick. After the last data bit it takes the "data complete" transition to RX_STOP. |
| RX_STOP | Samples the stop bit, emits a one-cycle completion, and takes the "frame end" transition to RX_IDLE. |
| RX_BRKW | Entered from any state on "break seen". It takes the "line released" transition to RX_IDLE on the first high sample. |

Top module: `uart_addr_rx`

## Requirements
- R1: A low sample at a tick starts a frame. If the line is high at the 8th tick after that, the receiver returns to idle and no character is produced. A later valid frame is then received correctly.
- R2: With `nine_bit`=0, a frame is a start bit, 8 data bits (LSB first) and a stop bit. On acceptance, `rx_data` takes the 8 bits and `rx_bit9` takes the received stop bit.
- R3: With `nine_bit`=1, a frame is a start bit, 9 data bits (LSB first) and a stop bit. On acceptance, `rx_data` takes the first 8 bits and `rx_bit9` takes the ninth.
- R4: A character that completes while `rx_flag` is 1 (and is not being cleared in that cycle) is lost: `rx_data` and `rx_bit9` keep their values.
- R5: With `nine_bit`=0 and `mp_en`=1, a character with a 0 stop bit is not loaded and does not raise `rx_flag`.
- R6: With `nine_bit`=1 and `mp_en`=1, a character whose ninth bit is 0 does not raise `rx_flag`.
- R7: With `nine_bit`=1 and `mp_en`=1, an address character (ninth bit 1) is accepted if it equals `own_addr` in every bit position where `addr_mask` is 1. Positions where the mask is 0 are ignored.
- R8: The same address character is also accepted if it has a 1 in every bit position where `own_addr | addr_mask` is 1. This is the broadcast match.
- R9: An address character that matches neither the masked own address nor the broadcast address does not raise `rx_flag`.
- R10: A 0 stop bit sets `frame_err`. The flag stays set until `stat_clr` is strobed.
- R11: When the line has been sampled low for 11 consecutive bit times (176 ticks), `break_flag` is set. The receiver produces no character until the line is sampled high, and it then receives normally.
- R12: `break_flag` stays set through later traffic until `stat_clr` is strobed.
- R13: A character that completes in the same cycle as `flag_clr` is accepted. `rx_flag` is 1 afterwards, because the set takes priority over the clear.
- R14: After reset, `rx_flag`, `frame_err`, `break_flag`, `rx_data` and `rx_bit9` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| nine_bit | input | 1 | 0: 8 data bits per frame; 1: 9 data bits per frame |
| mp_en | input | 1 | Multiprocessor enable; turns on stop-bit gating and address filtering |
| own_addr | input | 8 | Own address of this node |
| addr_mask | input | 8 | Mask of the own-address bits that must match |
| flag_clr | input | 1 | Strobe that clears `rx_flag` |
| stat_clr | input | 1 | Strobe that clears `frame_err` and `break_flag` |
| rx_data | output | 8 | Last accepted character |
| rx_bit9 | output | 1 | Ninth bit, or the stop bit in 8-bit mode |
| rx_flag | output | 1 | Character available |
| frame_err | output | 1 | A stop bit was sampled low |
| break_flag | output | 1 | Break condition seen |

## Verification
Loading a finished character and a software clear of the receive flag can land in the same clock cycle. The bench provokes this collision by repeating one pair of frames many times. Each time, it moves a single-cycle `flag_clr` pulse one clock further across the stop bit. So one pass puts the pulse exactly on the load cycle without knowing that cycle in advance. Every pass must end in one of two states: the new byte with the flag set, or the old byte with the flag clear. A cleared flag next to a new byte shows that the clear won the collision. The sweep must also produce both outcomes, which shows that the pulse really crossed the load cycle.

// File: rtl/uart_arx_pkg.sv
package uart_arx_pkg;

    // Frame receiver states
    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_STOP  = 3'd3,
        RX_BRKW  = 3'd4
    } rx_state_e;

endpackage

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_arx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              nine_bit,
    input  logic              brk_hit,
    output logic              done,
    output logic [DATA_W-1:0] f_data,
    output logic              f_bit9,
    output logic              f_stop
);

    localparam int CNT_W = $clog2(OVS);
    localparam int MID   = OVS / 2 - 1;
    localparam int IDX_W = $clog2(DATA_W + 2);
    localparam int SR_W  = DATA_W + 1;

    rx_state_e         state, state_n;
    logic [CNT_W-1:0]  tcnt;
    logic [IDX_W-1:0]  bidx;
    logic [SR_W-1:0]   shreg;
    logic [IDX_W-1:0]  last_idx;
    logic              at_mid, at_end;
    logic [CNT_W-1:0]  tcnt_wrap;

    assign last_idx  = nine_bit ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
    assign at_mid    = tick && (tcnt == CNT_W'(MID));
    assign at_end    = tick && (tcnt == CNT_W'(OVS - 1));
    assign tcnt_wrap = (tcnt == CNT_W'(OVS - 1)) ? '0 : tcnt + 1'b1;

    // Next-state decision
    always_comb begin
        state_n = state;
        if (brk_hit) begin
            state_n = RX_BRKW;
        end else begin
            unique case (state)
                RX_IDLE:  if (tick && !rxd) state_n = RX_START;
                RX_START: if (at_mid) state_n = rxd ? RX_IDLE : RX_DATA;
                RX_DATA:  if (at_end && (bidx == last_idx)) state_n = RX_STOP;
                RX_STOP:  if (at_end) state_n = RX_IDLE;
                RX_BRKW:  if (tick && rxd) state_n = RX_IDLE;
                default:  state_n = RX_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_n;
    end

    // Counters, shifter and frame outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt   <= '0;
            bidx   <= '0;
            shreg  <= '0;
            done   <= 1'b0;
            f_data <= '0;
            f_bit9 <= 1'b0;
            f_stop <= 1'b0;
        end else begin
            done <= 1'b0;
            if (brk_hit) begin
                tcnt <= '0;
                bidx <= '0;
            end else begin
                unique case (state)
                    RX_IDLE: begin
                        tcnt <= '0;
                        bidx <= '0;
                    end
                    RX_START: begin
                        if (tick) tcnt <= at_mid ? '0 : tcnt + 1'b1;
                    end
                    RX_DATA: begin
                        if (tick) tcnt <= tcnt_wrap;
                        if (at_end) begin
                            shreg <= {rxd, shreg[SR_W-1:1]};
                            bidx  <= bidx + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (tick) tcnt <= tcnt_wrap;
                        if (at_end) begin
                            done   <= 1'b1;
                            f_stop <= rxd;
                            if (nine_bit) begin
                                f_data <= shreg[DATA_W-1:0];
                                f_bit9 <= shreg[DATA_W];
                            end else begin
                                f_data <= shreg[DATA_W:1];
                                f_bit9 <= rxd;
                            end
                        end
                    end
                    RX_BRKW: tcnt <= '0;
                    default: tcnt <= '0;
                endcase
            end
        end
    end

    AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && at_mid && rxd && !brk_hit) |=> (state == RX_IDLE)); // R1

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2

    AST_BRK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        brk_hit |=> (state == RX_BRKW)); // R11

endmodule

// File: rtl/rx_break_det.sv
module rx_break_det #(
    parameter int OVS      = 16,
    parameter int BRK_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxd,
    input  logic stat_clr,
    output logic brk_hit,
    output logic break_flag
);

    localparam int LIM  = OVS * BRK_BITS;
    localparam int BC_W = $clog2(LIM + 1);

    logic [BC_W-1:0] lcnt;

    assign brk_hit = tick && !rxd && (lcnt == BC_W'(LIM - 1));

    // Count consecutive low ticks, saturating so the break fires once
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcnt <= '0;
        end else if (tick) begin
            if (rxd)                      lcnt <= '0;
            else if (lcnt != BC_W'(LIM))  lcnt <= lcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        break_flag <= 1'b0;
        else if (brk_hit)  break_flag <= 1'b1;
        else if (stat_clr) break_flag <= 1'b0;
    end

    AST_BRK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (break_flag && !stat_clr) |=> break_flag); // R12

    AST_BRK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !brk_hit) |=> !break_flag); // R12

endmodule

// File: rtl/rx_accept.sv
module rx_accept #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] f_data,
    input  logic              f_bit9,
    input  logic              f_stop,
    input  logic              nine_bit,
    input  logic              mp_en,
    input  logic [DATA_W-1:0] own_addr,
    input  logic [DATA_W-1:0] addr_mask,
    input  logic              flag_clr,
    input  logic              stat_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_flag,
    output logic              frame_err
);

    logic [DATA_W-1:0] bcast;
    logic              given_hit, bcast_hit, pass, load, flag_busy;

    assign bcast     = own_addr | addr_mask;
    assign given_hit = ((f_data ^ own_addr) & addr_mask) == '0;
    assign bcast_hit = ((f_data ^ bcast) & bcast) == '0;
    assign flag_busy = rx_flag && !flag_clr;

    always_comb begin
        if (nine_bit) pass = !mp_en || (f_bit9 && (given_hit || bcast_hit));
        else          pass = !mp_en || f_stop;
        load = done && !flag_busy && pass;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_bit9 <= 1'b0;
            rx_flag <= 1'b0;
        end else if (load) begin
            rx_data <= f_data;
            rx_bit9 <= f_bit9;
            rx_flag <= 1'b1;
        end else if (flag_clr) begin
            rx_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                frame_err <= 1'b0;
        else if (done && !f_stop)  frame_err <= 1'b1;
        else if (stat_clr)         frame_err <= 1'b0;
    end

    AST_OVERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && !flag_clr) |=> ($stable(rx_data) && rx_flag)); // R4

    AST_MP_DATA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nine_bit && mp_en && !f_bit9 && !rx_flag) |=> !rx_flag); // R6

    AST_ADDR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nine_bit && mp_en && !given_hit && !bcast_hit && !rx_flag) |=> !rx_flag); // R9

    AST_FE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !f_stop) |=> frame_err); // R10

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass && flag_clr) |=> rx_flag); // R13

endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
    parameter int OVS      = 16,
    parameter int DATA_W   = 8,
    parameter int BRK_BITS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick16,
    input  logic              rxd,
    input  logic              nine_bit,
    input  logic              mp_en,
    input  logic [DATA_W-1:0] own_addr,
    input  logic [DATA_W-1:0] addr_mask,
    input  logic              flag_clr,
    input  logic              stat_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_flag,
    output logic              frame_err,
    output logic              break_flag
);

    logic              brk_hit;
    logic              done;
    logic [DATA_W-1:0] f_data;
    logic              f_bit9, f_stop;

    rx_break_det #(.OVS(OVS), .BRK_BITS(BRK_BITS)) u_brk (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick16),
        .rxd        (rxd),
        .stat_clr   (stat_clr),
        .brk_hit    (brk_hit),
        .break_flag (break_flag)
    );

    rx_frame_fsm #(.OVS(OVS), .DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick16),
        .rxd      (rxd),
        .nine_bit (nine_bit),
        .brk_hit  (brk_hit),
        .done     (done),
        .f_data   (f_data),
        .f_bit9   (f_bit9),
        .f_stop   (f_stop)
    );

    rx_accept #(.DATA_W(DATA_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .f_data    (f_data),
        .f_bit9    (f_bit9),
        .f_stop    (f_stop),
        .nine_bit  (nine_bit),
        .mp_en     (mp_en),
        .own_addr  (own_addr),
        .addr_mask (addr_mask),
        .flag_clr  (flag_clr),
        .stat_clr  (stat_clr),
        .rx_data   (rx_data),
        .rx_bit9   (rx_bit9),
        .rx_flag   (rx_flag),
        .frame_err (frame_err)
    );

endmodule

// File: tb/sim_uart_addr_rx.sv
`timescale 1ns/1ps
module sim_uart_addr_rx;

    localparam int BITCLK = 32;  // 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       nine_bit = 1'b0;
    logic       mp_en = 1'b0;
    logic [7:0] own_addr = 8'h00;
    logic [7:0] addr_mask = 8'h00;
    logic       flag_clr = 1'b0;
    logic       stat_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_flag, frame_err, break_flag;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    uart_addr_rx u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick16(baud_tick16), .rxd(rxd),
        .nine_bit(nine_bit), .mp_en(mp_en), .own_addr(own_addr),
        .addr_mask(addr_mask), .flag_clr(flag_clr), .stat_clr(stat_clr),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_flag(rx_flag),
        .frame_err(frame_err), .break_flag(break_flag)
    );

    initial begin
        forever begin
            @(negedge clk);
            baud_tick16 = ~baud_tick16;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold_bits(input logic lvl, input int n);
        rxd = lvl;
        repeat (n * BITCLK) @(negedge clk);
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic pulse_stat();
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
    endtask

    // clr_at: clock index inside the stop bit at which flag_clr pulses, -1 for none
    task automatic send_frame(input logic [8:0] v, input logic nine, input logic stopb, input int clr_at);
        hold_bits(1'b0, 1);
        for (int i = 0; i < (nine ? 9 : 8); i++) hold_bits(v[i], 1);
        rxd = stopb;
        for (int c = 0; c < BITCLK; c++) begin
            flag_clr = (c == clr_at);
            @(negedge clk);
        end
        flag_clr = 1'b0;
        hold_bits(1'b1, 1);
    endtask

    task automatic t_reset();
        chk("R14 rx_flag", rx_flag, 0);
        chk("R14 frame_err", frame_err, 0);
        chk("R14 break_flag", break_flag, 0);
        chk("R14 rx_data", rx_data, 0);
        chk("R14 rx_bit9", rx_bit9, 0);
    endtask

    task automatic t_basic8();
        nine_bit = 0; mp_en = 0;
        send_frame(9'h0A5, 1'b0, 1'b1, -1);
        chk("R2 flag", rx_flag, 1);
        chk("R2 data", rx_data, 8'hA5);
        chk("R2 stop in bit9", rx_bit9, 1);
        chk("R10 no fe", frame_err, 0);
        pulse_clr();
        chk("R2 flag cleared", rx_flag, 0);
        send_frame(9'h03C, 1'b0, 1'b0, -1);
        chk("R2 data stop0", rx_data, 8'h3C);
        chk("R2 stop0 in bit9", rx_bit9, 0);
        chk("R10 fe set", frame_err, 1);
        pulse_stat();
        chk("R10 fe cleared", frame_err, 0);
    endtask

    task automatic t_overrun();
        send_frame(9'h081, 1'b0, 1'b1, -1);
        chk("R4 data kept", rx_data, 8'h3C);
        chk("R4 bit9 kept", rx_bit9, 0);
        chk("R4 flag", rx_flag, 1);
    endtask

    task automatic t_mp8();
        pulse_clr();
        mp_en = 1;
        send_frame(9'h066, 1'b0, 1'b0, -1);
        chk("R5 stop0 rejected", rx_flag, 0);
        chk("R5 data unchanged", rx_data, 8'h3C);
        send_frame(9'h066, 1'b0, 1'b1, -1);
        chk("R5 stop1 accepted", rx_flag, 1);
        chk("R5 data", rx_data, 8'h66);
        mp_en = 0;
        pulse_stat();
    endtask

    task automatic t_nine();
        nine_bit = 1; mp_en = 0;
        pulse_clr();
        send_frame(9'h05A, 1'b1, 1'b1, -1);
        chk("R3 flag", rx_flag, 1);
        chk("R3 data", rx_data, 8'h5A);
        chk("R3 bit9=0", rx_bit9, 0);
        pulse_clr();
        send_frame(9'h112, 1'b1, 1'b1, -1);
        chk("R3 data2", rx_data, 8'h12);
        chk("R3 bit9=1", rx_bit9, 1);
        pulse_clr();
        mp_en = 1;
        send_frame(9'h0E7, 1'b1, 1'b1, -1);
        chk("R6 data frame dropped", rx_flag, 0);
        chk("R6 data unchanged", rx_data, 8'h12);
    endtask

    task automatic t_addr();
        nine_bit = 1; mp_en = 1; own_addr = 8'hC6; addr_mask = 8'hF8;
        send_frame(9'h1C1, 1'b1, 1'b1, -1);
        chk("R7 given match flag", rx_flag, 1);
        chk("R7 given match data", rx_data, 8'hC1);
        pulse_clr();
        send_frame(9'h1FF, 1'b1, 1'b1, -1);
        chk("R8 broadcast FF", rx_flag, 1);
        chk("R8 broadcast data", rx_data, 8'hFF);
        pulse_clr();
        send_frame(9'h1FE, 1'b1, 1'b1, -1);
        chk("R8 broadcast FE", rx_flag, 1);
        pulse_clr();
        send_frame(9'h1D6, 1'b1, 1'b1, -1);
        chk("R9 miss D6", rx_flag, 0);
        send_frame(9'h1FC, 1'b1, 1'b1, -1);
        chk("R9 miss FC", rx_flag, 0);
        chk("R9 data unchanged", rx_data, 8'hFE);
        mp_en = 0; nine_bit = 0;
    endtask

    task automatic t_glitch();
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        hold_bits(1'b1, 2);
        chk("R1 glitch ignored", rx_flag, 0);
        send_frame(9'h096, 1'b0, 1'b1, -1);
        chk("R1 next frame flag", rx_flag, 1);
        chk("R1 next frame data", rx_data, 8'h96);
    endtask

    task automatic t_break();
        pulse_clr();
        pulse_stat();
        hold_bits(1'b0, 12);
        chk("R11 break set", break_flag, 1);
        pulse_clr();
        hold_bits(1'b0, 3);
        chk("R11 idle during break", rx_flag, 0);
        chk("R12 break held", break_flag, 1);
        hold_bits(1'b1, 2);
        send_frame(9'h04B, 1'b0, 1'b1, -1);
        chk("R11 resume flag", rx_flag, 1);
        chk("R11 resume data", rx_data, 8'h4B);
        chk("R12 break after traffic", break_flag, 1);
        pulse_stat();
        chk("R12 break cleared", break_flag, 0);
    endtask

    task automatic t_race();
        bit saw_new = 0;
        bit saw_old = 0;
        for (int k = 0; k < BITCLK; k++) begin
            logic [7:0] oldv = 8'(k);
            logic [7:0] newv = ~8'(k);
            pulse_clr();
            send_frame({1'b0, oldv}, 1'b0, 1'b1, -1);
            send_frame({1'b0, newv}, 1'b0, 1'b1, k);
            if (rx_flag === 1'b1 && rx_data === newv) saw_new = 1;
            else if (rx_flag === 1'b0 && rx_data === oldv) saw_old = 1;
            else begin
                nfail++;
                $display("FAIL R13 offset=%0d actual flag=%0b data=%0h expected flag=1 data=%0h or flag=0 data=%0h",
                         k, rx_flag, rx_data, newv, oldv);
            end
            nchk++;
        end
        chk("R13 some pulses before load", 32'(saw_new), 1);
        chk("R13 some pulses after load", 32'(saw_old), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic8();
        t_overrun();
        t_mp8();
        t_nine();
        t_addr();
        t_glitch();
        t_break();
        t_race();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule